// File: doc/BRIEF.md
# FIFO Status and Interrupt Register Block

This block sits next to a single-clock FIFO and gives software a view of its occupancy. It takes the FIFO's current entry count together with strobes that flag each attempted write and each attempted read. From these it derives a six-bit live status word: full, empty, above the upper watermark, below the lower watermark, write-when-full and read-when-empty. Software reaches it over a simple word-wide register bus. Register writes take effect at the clock edge, and read data is a combinational function of the address.

Each live status bit latches into a sticky event register, which software clears by writing ones. A per-bit enable mask selects which new events raise the single level interrupt. The interrupt stays asserted until every event that is both pending and enabled has been cleared. The two watermark thresholds can be programmed. Any value written to them is saturated into a legal range, so the comparisons never see a threshold of zero or one at or above the full count.

Top module: `fifo_csr`

## Requirements
- R1: After reset the event register and enable mask read 0, the upper threshold reads DEPTH-1, the lower threshold reads 1, and the interrupt is low.
- R2: Offset 0 returns the fill level, zero-extended. Writes to offsets 0 and 1 change nothing. Offsets 6 and 7 read 0, and bits above a register's width read 0.
- R3: Status (offset 1) bit 0 is 1 exactly when the fill level equals DEPTH. Bit 1 is 1 exactly when the fill level is 0.
- R4: Status bit 2 is 1 when the fill level is strictly greater than the upper threshold. Bit 3 is 1 when the fill level is strictly less than the lower threshold.
- R5: Status bit 4 is 1 in a cycle where a write is attempted while the fill level equals DEPTH. Status bit 5 is 1 in a cycle where a read is attempted while the fill level is 0. Both are 0 otherwise.
- R6: At each clock edge, every status bit that is 1 sets the matching bit of the event register (offset 2). An event bit stays set until a write to offset 2 carries a 1 in that position. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: The interrupt goes high one clock edge after an event bit changes from 0 to 1 while the matching bit of the enable mask (offset 3, bits 5:0) is set. An event whose enable bit is clear does not raise it.
- R8: Once high, the interrupt stays high while any event bit that is set and enabled remains. It falls at the edge where the last such bit is cleared.
- R9: A write to the upper threshold (offset 4) or the lower threshold (offset 5) stores 1 if the written value is below 1, stores DEPTH-1 if the value is above DEPTH-1, and otherwise stores the value. The whole 32-bit value is compared.
- R10: The enable mask at offset 3 reads back the six bits last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_level | input | $clog2(DEPTH+1) | Current number of FIFO entries |
| wr_try | input | 1 | A write into the FIFO is attempted this cycle |
| rd_try | input | 1 | A read from the FIFO is attempted this cycle |
| reg_addr | input | 3 | Register word offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DEPTH set to 16, which makes the fill level five bits wide. With that depth the bench can reach the full count directly, set the upper watermark anywhere from 1 to 15, and write values well past 15 as well as all-ones words to show that both thresholds saturate. Keeping the depth small lets every fill value at the watermark boundaries be driven by hand, on both sides of each comparison.

// File: rtl/fifo_csr_pkg.sv
package fifo_csr_pkg;

    localparam int ST_W      = 6;
    localparam int ST_FULL   = 0;
    localparam int ST_EMPTY  = 1;
    localparam int ST_HIGH   = 2;
    localparam int ST_LOW    = 3;
    localparam int ST_OVF    = 4;
    localparam int ST_UNF    = 5;
    localparam int BUS_W     = 32;

    typedef enum logic [2:0] {
        OFS_FILL   = 3'd0,
        OFS_STAT   = 3'd1,
        OFS_EVENT  = 3'd2,
        OFS_ENABLE = 3'd3,
        OFS_HIGH   = 3'd4,
        OFS_LOW    = 3'd5
    } csr_ofs_e;

endpackage

// File: rtl/csr_status_gen.sv
module csr_status_gen
    import fifo_csr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic [FILL_W-1:0] fill,
    input  logic              wr_try,
    input  logic              rd_try,
    input  logic [FILL_W-1:0] thr_high,
    input  logic [FILL_W-1:0] thr_low,
    output logic [ST_W-1:0]   stat
);
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(DEPTH);

    always_comb begin
        stat          = '0;
        stat[ST_FULL] = (fill == FULL_CNT);
        stat[ST_EMPTY]= (fill == '0);
        stat[ST_HIGH] = (fill > thr_high);
        stat[ST_LOW]  = (fill < thr_low);
        stat[ST_OVF]  = wr_try && (fill == FULL_CNT);
        stat[ST_UNF]  = rd_try && (fill == '0);
    end
endmodule

// File: rtl/csr_thr_sat.sv
module csr_thr_sat
    import fifo_csr_pkg::*;
#(
    parameter int HI    = 15,
    parameter int OUT_W = 5
) (
    input  logic [BUS_W-1:0] wval,
    output logic [OUT_W-1:0] sat
);
    localparam logic [BUS_W-1:0] HI_V = BUS_W'(HI);

    always_comb begin
        if (wval < BUS_W'(1)) begin
            sat = OUT_W'(1);
        end else if (wval > HI_V) begin
            sat = OUT_W'(HI);
        end else begin
            sat = wval[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/csr_event_irq.sv
module csr_event_irq
    import fifo_csr_pkg::*;
(
    input  logic [ST_W-1:0] stat,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] ev_q,
    input  logic [ST_W-1:0] ie_q,
    input  logic            irq_q,
    output logic [ST_W-1:0] ev_d,
    output logic            irq_d
);
    logic [ST_W-1:0] rise;

    always_comb begin
        // set has priority over a same-cycle clear
        ev_d  = (ev_q & ~clr_mask) | stat;
        rise  = ev_d & ~ev_q;
        irq_d = (|(rise & ie_q)) || (irq_q && (|(ev_d & ie_q)));
    end
endmodule

// File: rtl/fifo_csr.sv
module fifo_csr
    import fifo_csr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill_level,
    input  logic              wr_try,
    input  logic              rd_try,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int THR_MAX = DEPTH - 1;

    typedef struct packed {
        logic [ST_W-1:0]   ev;
        logic [ST_W-1:0]   ie;
        logic [FILL_W-1:0] thr_high;
        logic [FILL_W-1:0] thr_low;
        logic              irq;
    } csr_state_t;

    csr_state_t q, d;

    logic [ST_W-1:0]   stat_now;
    logic [ST_W-1:0]   clr_mask;
    logic [ST_W-1:0]   ev_nxt;
    logic              irq_nxt;
    logic [FILL_W-1:0] high_sat;
    logic [FILL_W-1:0] low_sat;
    logic [ST_W-1:0]   ev_q;
    logic [ST_W-1:0]   ie_q;
    logic [FILL_W-1:0] thr_high_q;
    logic [FILL_W-1:0] thr_low_q;

    assign ev_q       = q.ev;
    assign ie_q       = q.ie;
    assign thr_high_q = q.thr_high;
    assign thr_low_q  = q.thr_low;

    csr_status_gen #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_stat (
        .fill     (fill_level),
        .wr_try   (wr_try),
        .rd_try   (rd_try),
        .thr_high (q.thr_high),
        .thr_low  (q.thr_low),
        .stat     (stat_now)
    );

    csr_thr_sat #(.HI(THR_MAX), .OUT_W(FILL_W)) u_sat_high (
        .wval (reg_wdata),
        .sat  (high_sat)
    );

    csr_thr_sat #(.HI(THR_MAX), .OUT_W(FILL_W)) u_sat_low (
        .wval (reg_wdata),
        .sat  (low_sat)
    );

    assign clr_mask = (reg_wr_en && reg_addr == OFS_EVENT) ? reg_wdata[ST_W-1:0] : '0;

    csr_event_irq u_evt (
        .stat     (stat_now),
        .clr_mask (clr_mask),
        .ev_q     (q.ev),
        .ie_q     (q.ie),
        .irq_q    (q.irq),
        .ev_d     (ev_nxt),
        .irq_d    (irq_nxt)
    );

    always_comb begin
        d     = q;
        d.ev  = ev_nxt;
        d.irq = irq_nxt;
        if (reg_wr_en) begin
            case (reg_addr)
                OFS_ENABLE: d.ie       = reg_wdata[ST_W-1:0];
                OFS_HIGH:   d.thr_high = high_sat;
                OFS_LOW:    d.thr_low  = low_sat;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ev       <= '0;
            q.ie       <= '0;
            q.thr_high <= FILL_W'(THR_MAX);
            q.thr_low  <= FILL_W'(1);
            q.irq      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_FILL:   reg_rdata[FILL_W-1:0] = fill_level;
            OFS_STAT:   reg_rdata[ST_W-1:0]   = stat_now;
            OFS_EVENT:  reg_rdata[ST_W-1:0]   = q.ev;
            OFS_ENABLE: reg_rdata[ST_W-1:0]   = q.ie;
            OFS_HIGH:   reg_rdata[FILL_W-1:0] = q.thr_high;
            OFS_LOW:    reg_rdata[FILL_W-1:0] = q.thr_low;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = q.irq;

endmodule

// File: rtl/fifo_csr_chk.sv
module fifo_csr_chk
    import fifo_csr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        reg_addr,
    input logic              reg_wr_en,
    input logic [31:0]       reg_wdata,
    input logic [ST_W-1:0]   stat,
    input logic [ST_W-1:0]   ev_q,
    input logic [ST_W-1:0]   ie_q,
    input logic [FILL_W-1:0] thr_high_q,
    input logic [FILL_W-1:0] thr_low_q,
    input logic              irq
);
    logic [ST_W-1:0] clr;
    logic [ST_W-1:0] keep;

    assign clr  = (reg_wr_en && reg_addr == 3'd2) ? reg_wdata[ST_W-1:0] : '0;
    assign keep = ev_q & ~clr;

    // R6: uncleared event bits survive the edge
    a_r6_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != '0) |=> ((ev_q & $past(keep)) == $past(keep)));

    // R6: live status bits land in the event register
    a_r6_event_set: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != '0) |=> ((ev_q & $past(stat)) == $past(stat)));

    // R7: a new enabled event raises the interrupt
    a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & ~ev_q & ie_q)) |=> irq);

    // R8: interrupt held while an enabled event remains uncleared
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (|(keep & ie_q))) |=> irq);

    // R9: stored thresholds always lie in the legal range
    a_r9_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_high_q >= FILL_W'(1)) && (thr_high_q <= FILL_W'(DEPTH - 1)) &&
        (thr_low_q  >= FILL_W'(1)) && (thr_low_q  <= FILL_W'(DEPTH - 1)));

endmodule

bind fifo_csr fifo_csr_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .stat       (stat_now),
    .ev_q       (ev_q),
    .ie_q       (ie_q),
    .thr_high_q (thr_high_q),
    .thr_low_q  (thr_low_q),
    .irq        (irq)
);

// File: tb/tb_fifo_csr.sv
module tb_fifo_csr;

    localparam int DEPTH  = 16;
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int CLK_P  = 10;

    // {fill[4:0], wr_try, rd_try, expected status[5:0]} at default thresholds 15 / 1
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd0,  1'b0, 1'b0, 6'b001010},
        {5'd0,  1'b0, 1'b1, 6'b101010},
        {5'd1,  1'b0, 1'b0, 6'b000000},
        {5'd8,  1'b1, 1'b1, 6'b000000},
        {5'd15, 1'b0, 1'b0, 6'b000000},
        {5'd16, 1'b0, 1'b0, 6'b000101},
        {5'd16, 1'b1, 1'b0, 6'b010101},
        {5'd16, 1'b0, 1'b1, 6'b000101},
        {5'd0,  1'b1, 1'b0, 6'b001010}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FILL_W-1:0] fill_level = '0;
    logic              wr_try = 1'b0;
    logic              rd_try = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic              reg_wr_en = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int total = 0;
    int bad   = 0;

    fifo_csr #(.DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_level (fill_level),
        .wr_try     (wr_try),
        .rd_try     (rd_try),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        fill_level = 5'd5;
        #1;

        // R1 reset values
        rd_chk(3'd2, "R1 event", 32'h0);
        rd_chk(3'd3, "R1 enable", 32'h0);
        rd_chk(3'd4, "R1 high thr", 32'd15);
        rd_chk(3'd5, "R1 low thr", 32'd1);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 fill register, read-only offsets, unused offsets
        fill_level = 5'd9;
        rd_chk(3'd0, "R2 fill", 32'd9);
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, "R2 fill after write", 32'd9);
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, "R2 status after write", 32'h0);
        rd_chk(3'd6, "R2 offset 6", 32'h0);
        rd_chk(3'd7, "R2 offset 7", 32'h0);

        // R3 R4 R5 status table
        for (int i = 0; i < NVEC; i++) begin
            fill_level = VEC[i][12:8];
            wr_try     = VEC[i][7];
            rd_try     = VEC[i][6];
            rd_chk(3'd1, $sformatf("R3/R4/R5 vec %0d", i), {26'b0, VEC[i][5:0]});
            tick();
        end
        wr_try = 1'b0;
        rd_try = 1'b0;

        // R6 clear, set, sticky, set-wins
        fill_level = 5'd5;
        wr(3'd2, 32'h3F);
        rd_chk(3'd2, "R6 cleared", 32'h0);
        fill_level = 5'd0;
        tick();
        fill_level = 5'd5;
        rd_chk(3'd2, "R6 empty event set", 32'h0A);
        tick();
        rd_chk(3'd2, "R6 sticky", 32'h0A);
        wr(3'd2, 32'h02);
        rd_chk(3'd2, "R6 partial clear", 32'h08);
        fill_level = 5'd0;
        wr(3'd2, 32'h3F);
        fill_level = 5'd5;
        rd_chk(3'd2, "R6 set wins", 32'h0A);
        wr(3'd2, 32'h3F);

        // R7 masked event does not interrupt
        fill_level = 5'd16;
        tick();
        fill_level = 5'd5;
        chk("R7 masked no irq", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h3F);

        // R10 enable readback, R7 enabled event raises
        wr(3'd3, 32'hFFFF_FF81);
        rd_chk(3'd3, "R10 enable readback", 32'h01);
        fill_level = 5'd16;
        tick();
        fill_level = 5'd5;
        chk("R7 irq raised", {31'b0, irq}, 32'h1);
        tick();
        chk("R8 irq held", {31'b0, irq}, 32'h1);

        // R8 hold until last enabled event cleared
        wr(3'd3, 32'h03);
        fill_level = 5'd0;
        tick();
        fill_level = 5'd5;
        wr(3'd2, 32'h01);
        chk("R8 irq held with bit1", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h02);
        chk("R8 irq dropped", {31'b0, irq}, 32'h0);
        rd_chk(3'd2, "R8 remaining events", 32'h0C);

        // R9 saturation
        wr(3'd4, 32'd0);
        rd_chk(3'd4, "R9 high below", 32'd1);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk(3'd4, "R9 high all ones", 32'd15);
        wr(3'd4, 32'd100);
        rd_chk(3'd4, "R9 high above", 32'd15);
        wr(3'd4, 32'd10);
        rd_chk(3'd4, "R9 high in range", 32'd10);
        wr(3'd5, 32'd0);
        rd_chk(3'd5, "R9 low below", 32'd1);
        wr(3'd5, 32'd40);
        rd_chk(3'd5, "R9 low above", 32'd15);
        wr(3'd5, 32'd4);
        rd_chk(3'd5, "R9 low in range", 32'd4);

        // R4 boundaries at programmed thresholds 10 / 4
        fill_level = 5'd11;
        rd_chk(3'd1, "R4 above high", 32'h04);
        fill_level = 5'd10;
        rd_chk(3'd1, "R4 at high", 32'h00);
        fill_level = 5'd3;
        rd_chk(3'd1, "R4 below low", 32'h08);
        fill_level = 5'd4;
        rd_chk(3'd1, "R4 at low", 32'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule